// File: doc/BRIEF.md
# ADC Burst Accumulator and Formatter

This block sits between an analog-to-digital converter and the register that software reads. On a start request it asks the converter for samples and sums the 12-bit results. With burst enabled, one start runs a chain of conversions whose length comes from an encoded repeat field. Each new request is issued as soon as the previous sample arrives. With burst disabled, each start yields exactly one conversion. The block then either replaces the result or adds the conversion to it, so that a running total builds up across separate starts until software clears it.

The completed sum sits in an 18-bit result register. It is presented on a 16-bit read port through a format stage. That stage either shifts the sum right by zero to three bits or left-justifies it, so that the top bit of a single sample lands on bit 15. Software reaches the configuration byte and the result through a one-bit register select. The converter side is a one-cycle request output and a sample valid/data input.

Top module: `adc_burst_acc`

## Requirements
- R1: After reset, reading either register returns 0, `done` is low and `conv_req` is low.
- R2: A write with `reg_sel`=0 stores bits 5:0 of `reg_wdata` (format in 5:3, repeat in 2:0) and bit 6 (accumulate enable). A read with `reg_sel`=0 returns bits 5:0 as written, and every higher bit, including bits 6 and 7, reads 0.
- R3: With `burst_en`=1, an accepted start runs 1, 4, 8, 16, 32 or 64 conversions for repeat codes 0 to 5, and 64 for codes 6 and 7. The result becomes the sum of those samples and `done` pulses for one cycle, both one edge after the last sample is taken.
- R4: With `burst_en`=0, a start runs exactly one conversion, whatever the repeat field holds.
- R5: With `burst_en`=0 and accumulate enable 0, a completed conversion replaces the result with that sample.
- R6: With `burst_en`=0 and accumulate enable 1, a completed conversion adds the sample to the previous result, modulo 2^18.
- R7: A write with `reg_sel`=1 (software writes 0x0000) clears the result and any running sum one edge later.
- R8: A clear write taken in the same cycle as a sample makes that sample the first term of the new sum.
- R9: The read value with `reg_sel`=1 is a function of format code f and the 18-bit result S. For f = 0, 1, 2 or 3 it is bits f+15..f of S. For f = 4 it is S shifted left by 4, low 16 bits. For f = 5, 6 or 7 it is as for f = 0.
- R10: A sample that arrives while no operation is running is ignored. A start that arrives while an operation is running is ignored.
- R11: The result changes only on the edge that completes an operation or on a clear write.
- R12: `conv_req` is high, combinationally, in the cycle a start is accepted and in the cycle a non-final sample is taken, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register select: 0 configuration, 1 result |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for the selected register |
| burst_en | input | 1 | Burst mode enable |
| start | input | 1 | Start request |
| conv_req | output | 1 | Request one conversion from the converter |
| smp_valid | input | 1 | Converter sample strobe |
| smp_data | input | 12 | Converter sample |
| done | output | 1 | One-cycle completion pulse |

## Verification
`conv_req` is combinational and due in the same cycle as the start or sample that causes it. `done`, the new result and a clear all appear one rising edge after the strobe that causes them. A configuration write reads back one edge later. The bench drives inputs shortly after each falling edge and compares every output at the next falling edge. It compares them against a model that advances on each rising edge using only the inputs the bench drove, so each expected value is checked in the exact cycle it is due. The converter model answers each request exactly three edges later. Because of this fixed delay, the cycles in which a clear write coincides with a sample can be placed deliberately.

// File: rtl/adc_acc_pkg.sv
package adc_acc_pkg;
   localparam int RPT_LOG = 6;
   localparam int RPT_CNT_W = RPT_LOG + 1;

   typedef struct packed {
      logic       acc_en;
      logic [2:0] fmt;
      logic [2:0] rpt;
   } acc_cfg_t;

   function automatic logic [RPT_CNT_W-1:0] rpt_count(input logic [2:0] code);
      case (code)
         3'd0:    return RPT_CNT_W'(1);
         3'd1:    return RPT_CNT_W'(4);
         3'd2:    return RPT_CNT_W'(8);
         3'd3:    return RPT_CNT_W'(16);
         3'd4:    return RPT_CNT_W'(32);
         default: return RPT_CNT_W'(64);
      endcase
   endfunction
endpackage

// File: rtl/adc_acc_cfg.sv
module adc_acc_cfg
   import adc_acc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we_i,
   input  logic [7:0] wdata_i,
   output acc_cfg_t   cfg_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_o <= '0;
      end else if (we_i) begin
         cfg_o.acc_en <= wdata_i[6];
         cfg_o.fmt    <= wdata_i[5:3];
         cfg_o.rpt    <= wdata_i[2:0];
      end
   end
endmodule

// File: rtl/adc_acc_seq.sv
module adc_acc_seq
   import adc_acc_pkg::*;
#(
   parameter int CNT_W = RPT_CNT_W
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       burst_i,
   input  logic [2:0] rpt_i,
   input  logic       smp_valid_i,
   output logic       load_o,
   output logic       take_o,
   output logic       last_o,
   output logic       conv_req_o,
   output logic       done_o,
   output logic       busy_o
);
   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;

   assign load_o     = start_i & ~busy_q;
   assign take_o     = smp_valid_i & busy_q;
   assign last_o     = take_o & (cnt_q == CNT_W'(1));
   assign conv_req_o = load_o | (take_o & ~last_o);
   assign busy_o     = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= last_o;
         if (load_o) begin
            busy_q <= 1'b1;
            cnt_q  <= burst_i ? CNT_W'(rpt_count(rpt_i)) : CNT_W'(1);
         end else if (take_o) begin
            cnt_q <= cnt_q - CNT_W'(1);
            if (last_o) busy_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/adc_acc_sum.sv
module adc_acc_sum #(
   parameter int SMP_W = 12,
   parameter int ACC_W = 18
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             seed_i,
   input  logic             take_i,
   input  logic             last_i,
   input  logic             clr_i,
   input  logic [SMP_W-1:0] smp_i,
   output logic [ACC_W-1:0] res_o
);
   logic [ACC_W-1:0] sum_q;
   logic [ACC_W-1:0] base;
   logic [ACC_W-1:0] nxt;

   assign base = clr_i ? '0 : sum_q;
   assign nxt  = base + ACC_W'(smp_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q <= '0;
         res_o <= '0;
      end else begin
         if (load_i)                sum_q <= (clr_i | ~seed_i) ? '0 : res_o;
         else if (take_i && !last_i) sum_q <= nxt;
         else if (clr_i)            sum_q <= '0;

         if (take_i && last_i) res_o <= nxt;
         else if (clr_i)       res_o <= '0;
      end
   end
endmodule

// File: rtl/adc_acc_fmt.sv
module adc_acc_fmt #(
   parameter int SMP_W     = 12,
   parameter int ACC_W     = 18,
   parameter int OUT_W     = 16,
   parameter int MAX_SHIFT = 3
)(
   input  logic [ACC_W-1:0] res_i,
   input  logic [2:0]       fmt_i,
   output logic [OUT_W-1:0] out_o
);
   localparam int NSH   = MAX_SHIFT + 1;
   localparam int LJ    = OUT_W - SMP_W;
   localparam int LJ_CODE = NSH;

   logic [ACC_W-1:0]    sh [NSH];
   logic [ACC_W+LJ-1:0] lj;

   for (genvar k = 0; k < NSH; k++) begin : g_shift
      assign sh[k] = res_i >> k;
   end

   if (LJ > 0) begin : g_lj_pad
      assign lj = {res_i, {LJ{1'b0}}};
   end else begin : g_lj_flat
      assign lj = res_i;
   end

   always_comb begin
      if (int'(fmt_i) < NSH)          out_o = sh[fmt_i[$clog2(NSH)-1:0]][OUT_W-1:0];
      else if (int'(fmt_i) == LJ_CODE) out_o = lj[OUT_W-1:0];
      else                             out_o = sh[0][OUT_W-1:0];
   end
endmodule

// File: rtl/adc_burst_acc.sv
module adc_burst_acc
   import adc_acc_pkg::*;
#(
   parameter int SMP_W = 12,
   parameter int OUT_W = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_sel,
   input  logic             reg_we,
   input  logic [OUT_W-1:0] reg_wdata,
   output logic [OUT_W-1:0] reg_rdata,
   input  logic             burst_en,
   input  logic             start,
   output logic             conv_req,
   input  logic             smp_valid,
   input  logic [SMP_W-1:0] smp_data,
   output logic             done
);
   localparam int ACC_W = SMP_W + RPT_LOG;

   if (OUT_W < SMP_W || OUT_W < 8) begin : g_bad_out
      $error("adc_burst_acc: OUT_W must hold a sample and the configuration byte");
   end
   if (ACC_W < OUT_W) begin : g_bad_acc
      $error("adc_burst_acc: accumulator narrower than the read port");
   end

   acc_cfg_t         cfg;
   logic             load_w, take_w, last_w, busy_w;
   logic [ACC_W-1:0] res_w;
   logic [OUT_W-1:0] fmt_w;

   adc_acc_cfg u_cfg (
      .clk(clk), .rst_n(rst_n), .we_i(reg_we & ~reg_sel),
      .wdata_i(reg_wdata[7:0]), .cfg_o(cfg)
   );

   adc_acc_seq u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start), .burst_i(burst_en),
      .rpt_i(cfg.rpt), .smp_valid_i(smp_valid), .load_o(load_w),
      .take_o(take_w), .last_o(last_w), .conv_req_o(conv_req),
      .done_o(done), .busy_o(busy_w)
   );

   adc_acc_sum #(.SMP_W(SMP_W), .ACC_W(ACC_W)) u_sum (
      .clk(clk), .rst_n(rst_n), .load_i(load_w),
      .seed_i(cfg.acc_en & ~burst_en), .take_i(take_w), .last_i(last_w),
      .clr_i(reg_we & reg_sel), .smp_i(smp_data), .res_o(res_w)
   );

   adc_acc_fmt #(.SMP_W(SMP_W), .ACC_W(ACC_W), .OUT_W(OUT_W)) u_fmt (
      .res_i(res_w), .fmt_i(cfg.fmt), .out_o(fmt_w)
   );

   assign reg_rdata = reg_sel ? fmt_w : OUT_W'({cfg.fmt, cfg.rpt});
endmodule

// File: rtl/adc_burst_acc_chk.sv
module adc_burst_acc_chk #(
   parameter int OUT_W = 16,
   parameter int ACC_W = 18
)(
   input logic             clk,
   input logic             rst_n,
   input logic             reg_sel,
   input logic             reg_we,
   input logic [OUT_W-1:0] reg_rdata,
   input logic             start,
   input logic             smp_valid,
   input logic             conv_req,
   input logic             done,
   input logic             busy,
   input logic [ACC_W-1:0] res
);
   // R3
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R12
   req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |-> (start || smp_valid));

   // R11
   res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!done && !$past(reg_we && reg_sel)) |-> $stable(res));

   // R2
   cfg_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_sel |-> (reg_rdata[OUT_W-1:6] == '0));

   // R10
   idle_smp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && smp_valid && !(reg_we && reg_sel)) |=> $stable(res));
endmodule

bind adc_burst_acc adc_burst_acc_chk #(.OUT_W(OUT_W), .ACC_W(ACC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
   .reg_rdata(reg_rdata), .start(start), .smp_valid(smp_valid),
   .conv_req(conv_req), .done(done), .busy(busy_w), .res(res_w)
);

// File: tb/adc_burst_acc_tb.sv
module adc_burst_acc_tb;
   localparam int PER = 10;
   localparam int LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_sel = 1'b1, reg_we = 1'b0, burst_en = 1'b0, start = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        conv_req, done;
   logic        smp_valid = 1'b0;
   logic [11:0] smp_data = '0;

   int checks = 0, errors = 0, cyc = 0;
   string tag = "R1";
   bit checking = 0, all_ones = 0, spur = 0;

   // behavioural reference
   bit        m_busy = 0, m_done = 0, m_acc = 0;
   int        m_cnt = 0;
   logic [2:0]  m_fmt = 0, m_rpt = 0;
   logic [17:0] m_sum = 0, m_res = 0;
   int        q_due[$];

   adc_burst_acc u_dut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .burst_en(burst_en),
      .start(start), .conv_req(conv_req), .smp_valid(smp_valid),
      .smp_data(smp_data), .done(done)
   );

   always #(PER/2) clk = ~clk;

   function automatic int cnt_of(input logic [2:0] c);
      case (c)
         0: return 1;  1: return 4;  2: return 8;
         3: return 16; 4: return 32; default: return 64;
      endcase
   endfunction

   function automatic logic [15:0] exp_rd(input logic s);
      logic [17:0] t;
      if (!s) return {10'd0, m_fmt, m_rpt};
      if (m_fmt <= 3) t = m_res >> m_fmt;
      else if (m_fmt == 4) t = m_res << 4;
      else t = m_res;
      return t[15:0];
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_acc = 0; m_cnt = 0;
         m_fmt = 0; m_rpt = 0; m_sum = 0; m_res = 0; q_due.delete();
      end else begin
         bit clr, req;
         logic [17:0] s;
         cyc++;
         clr = reg_we && reg_sel;
         req = (!m_busy && start) || (m_busy && smp_valid && m_cnt > 1);
         m_done = 0;
         if (!m_busy && start) begin
            m_busy = 1;
            m_cnt = burst_en ? cnt_of(m_rpt) : 1;
            m_sum = (clr || burst_en || !m_acc) ? 18'd0 : m_res;
            if (clr) m_res = 0;
         end else if (m_busy && smp_valid) begin
            s = (clr ? 18'd0 : m_sum) + 18'(smp_data);
            if (m_cnt == 1) begin
               m_res = s; m_busy = 0; m_done = 1;
            end else begin
               m_sum = s; m_cnt--;
               if (clr) m_res = 0;
            end
         end else if (clr) begin
            m_sum = 0; m_res = 0;
         end
         if (reg_we && !reg_sel) begin
            m_acc = reg_wdata[6]; m_fmt = reg_wdata[5:3]; m_rpt = reg_wdata[2:0];
         end
         if (req) q_due.push_back(cyc + LAT);
      end
   end

   // converter model
   always @(negedge clk) begin
      #2;
      smp_valid = spur;
      if (q_due.size() > 0 && q_due[0] == cyc + 1) begin
         void'(q_due.pop_front());
         smp_valid = 1'b1;
         smp_data = all_ones ? 12'hFFF : 12'($urandom);
      end else if (spur) begin
         smp_data = 12'($urandom);
      end
   end

   // per-cycle comparison
   always @(negedge clk) begin
      if (rst_n && checking) begin
         chk({tag, " read"}, reg_rdata, exp_rd(reg_sel));
         chk({tag, " done"}, 16'(done), 16'(m_done));
         chk("R12 request", 16'(conv_req),
             16'((!m_busy && start) || (m_busy && smp_valid && m_cnt > 1)));
      end
   end

   always @(posedge clk) begin
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic tick();
      @(negedge clk); #1;
   endtask

   task automatic wcfg(input logic [7:0] v);
      reg_sel = 0; reg_we = 1; reg_wdata = {8'h00, v};
      tick();
      reg_we = 0; reg_sel = 1; reg_wdata = '0;
   endtask

   task automatic wclr();
      reg_sel = 1; reg_we = 1; reg_wdata = 16'h0000;
      tick();
      reg_we = 0;
   endtask

   task automatic run_op(input logic b);
      burst_en = b; start = 1;
      tick();
      start = 0;
      while (m_busy) tick();
      tick();
   endtask

   initial begin
      repeat (4) tick();
      rst_n = 1;
      tick();
      // R1 reset state
      chk("R1 result", reg_rdata, 16'h0000);
      chk("R1 done", 16'(done), 16'd0);
      chk("R1 request", 16'(conv_req), 16'd0);
      reg_sel = 0;
      tick();
      chk("R1 config", reg_rdata, 16'h0000);
      reg_sel = 1;
      checking = 1;

      tag = "R2";
      wcfg(8'hFF); reg_sel = 0; tick();
      chk("R2 readback", reg_rdata, 16'h003F);
      wcfg(8'h12); reg_sel = 0; tick(); reg_sel = 1; tick();

      tag = "R4/R5";
      wcfg(8'h03);
      for (int i = 0; i < 4; i++) run_op(1'b0);

      tag = "R6";
      wcfg(8'h40);
      for (int i = 0; i < 4; i++) run_op(1'b0);
      all_ones = 1;
      for (int i = 0; i < 3; i++) run_op(1'b0);
      all_ones = 0;

      tag = "R7";
      wclr(); tick();
      chk("R7 cleared", reg_rdata, 16'h0000);
      run_op(1'b0);

      tag = "R8";
      burst_en = 0; start = 1;
      tick(); start = 0;
      tick();
      tick(); reg_we = 1; reg_sel = 1; reg_wdata = 16'h0000;
      tick(); reg_we = 0;
      while (m_busy) tick();
      tick();
      chk("R8 sample starts sum", reg_rdata, 16'(smp_data));
      wcfg(8'h00);

      tag = "R3/R11";
      for (int c = 0; c < 8; c++) begin
         all_ones = (c % 2) == 1;
         wcfg(8'(c));
         run_op(1'b1);
      end
      all_ones = 0;

      tag = "R9";
      wcfg(8'h02); run_op(1'b1);
      for (int f = 0; f < 8; f++) begin
         wcfg(8'((f << 3) | 2)); tick();
      end
      all_ones = 1;
      wcfg(8'h25); run_op(1'b1);
      wcfg(8'h20); tick();
      wcfg(8'h18); tick();
      all_ones = 0;

      tag = "R10";
      wcfg(8'h01);
      spur = 1; repeat (3) tick(); spur = 0; tick();
      burst_en = 1; start = 1; tick(); start = 0;
      tick(); start = 1; tick(); start = 0; tick(); start = 1; tick(); start = 0;
      while (m_busy) tick();
      tick();
      spur = 1; tick(); spur = 0; repeat (2) tick();

      checking = 0;
      tick();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule